// File: doc/BRIEF.md
# Serial Segment Data Receiver

This block is the loading front end of a multiplexed display driver that is filled over a three-wire serial link: an active-low select, a serial clock and a data line. While select is low the block takes one data bit on each rising serial clock edge, most significant bit first. It groups the bits into bytes and writes each byte into its own register as soon as its eighth bit arrives. The first four bytes of a frame are digit segment patterns, and the fifth is a trailer. The trailer's low nibble holds four special-segment bits. Its high nibble is a control code that sets how the backplane pins are used when several drivers are cascaded.

A frame may end after any whole byte, so a host can refresh only the first few digits. Each falling edge of select restarts the count at digit 1. The serial inputs are asynchronous to the block clock. They pass through a synchronizer of configurable depth, and edges are detected in the block clock domain, so the serial clock must be several block clocks slower than the block clock.

Top module: `seg_serial_rx`

## Requirements
- R1: A falling edge on `cs_n` clears the bit and byte counters. The next complete byte is always written to digit 1, whatever happened in the previous frame.
- R2: Bytes are taken most significant bit first. Frame bytes 1 to 4 go to `digit_q[7:0]`, `[15:8]`, `[23:16]` and `[31:24]` in that order.
- R3: Data is sampled only on rising `sclk` edges while `cs_n` is low. Serial clock edges while `cs_n` is high change no register.
- R4: A register changes only when the eighth bit of its byte arrives. When `cs_n` rises, an unfinished byte is dropped and every register keeps its earlier value.
- R5: Bits 3..0 of the fifth byte are written to `seg_sp[3:0]`, with bit 0 as special segment 1.
- R6: Control nibble (fifth byte bits 7..4) 4'b0011 selects standalone mode: `mode_q`=0, `bpa_osc_in`=0, `bpc_osc_out`=0.
- R7: Control nibble 4'b0001 selects cascade master mode: `mode_q`=1, `bpc_osc_out`=1, `bpa_osc_in`=0.
- R8: Control nibble 4'b1110 or 4'b0110 selects stopped slave mode: `mode_q`=2, `bpa_osc_in`=1, `bpc_osc_out`=0.
- R9: Any other control nibble leaves the mode unchanged. The special-segment bits of that byte are still written.
- R10: Bits after the fifth byte of a frame are ignored until `cs_n` falls again.
- R11: After reset all digits and special bits are zero and the mode is standalone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| digit_q | output | NUM_DIGITS*8 | Digit segment registers, digit 1 in the low byte |
| seg_sp | output | 4 | Special-segment bits |
| mode_q | output | 2 | Operating mode: 0 standalone, 1 master, 2 slave |
| bpa_osc_in | output | 1 | Backplane A pin used as oscillator input (slave) |
| bpc_osc_out | output | 1 | Backplane C pin drives the oscillator out (master) |

## Verification
The bench builds the block with its defaults: four digits and a two-stage synchronizer. Each serial clock phase lasts four block clocks, which is longer than the synchronizer and edge-detect delay. With four digits, a partial frame leaves real digits untouched. An overlong frame runs past the control byte into a sixth byte, and the tests of all four control codes can be chained so that the unknown-code case starts from a non-default mode.

// File: rtl/seg_rx_pkg.sv
// Package: shared constants, mode encoding and control-nibble decode
// for the serial segment data receiver.
package seg_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        MODE_ALONE  = 2'd0,
        MODE_MASTER = 2'd1,
        MODE_SLAVE  = 2'd2
    } rx_mode_t;

    // True when the nibble is one of the defined control codes.
    function automatic logic ctrl_known(input logic [NIB_W-1:0] nib);
        return (nib == 4'b0011) || (nib == 4'b0001) ||
               (nib == 4'b1110) || (nib == 4'b0110);
    endfunction

    // Next mode for a control nibble; unknown codes keep the current mode.
    function automatic rx_mode_t ctrl_decode(input logic [NIB_W-1:0] nib,
                                             input rx_mode_t cur);
        case (nib)
            4'b0011:          return MODE_ALONE;
            4'b0001:          return MODE_MASTER;
            4'b1110, 4'b0110: return MODE_SLAVE;
            default:          return cur;
        endcase
    endfunction

endpackage

// File: rtl/seg_rx_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the inputs are slow against clk; each bit is synchronized
// separately, so the bits of the bundle may skew by one clock.
module seg_rx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= RST_VAL;
                    else        pipe[0] <= d_async;
                end
            end else begin : g_next
                // Later flops let any metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/seg_rx_shift.sv
// Module: edge detection, bit/byte counting and shift register.
// Emits a one-cycle commit strobe with the byte index and value when
// the eighth bit of a byte arrives. Assumes synchronized inputs.
module seg_rx_shift
    import seg_rx_pkg::*;
#(
    parameter int FRAME_BYTES = 5,
    localparam int IDX_W = $clog2(FRAME_BYTES + 1),
    localparam int BIT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [BYTE_W-1:0] commit_byte
);

    logic              sclk_p, cs_p;
    logic              sclk_rise, cs_fall, clear, take;
    logic [BIT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  byte_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              last_bit;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            cs_p   <= 1'b1;
        end else begin
            sclk_p <= sclk_s;
            cs_p   <= cs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_p;
    assign cs_fall   = cs_p & ~cs_s;
    assign clear     = cs_s | cs_fall;
    assign take      = sclk_rise & ~clear & (byte_cnt < IDX_W'(FRAME_BYTES));
    assign last_bit  = (bit_cnt == BIT_W'(BYTE_W - 1));

    // Count bits and bytes; clear while deselected or on a select fall.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            shreg    <= '0;
        end else if (take) begin
            shreg <= {shreg[BYTE_W-2:0], sdi_s};
            if (last_bit) begin
                bit_cnt  <= '0;
                byte_cnt <= byte_cnt + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Register the commit strobe with the completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit      <= 1'b0;
            commit_idx  <= '0;
            commit_byte <= '0;
        end else begin
            commit <= take & last_bit;
            if (take && last_bit) begin
                commit_idx  <= byte_cnt;
                commit_byte <= {shreg[BYTE_W-2:0], sdi_s};
            end
        end
    end

    AST_CS_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (bit_cnt == '0 && byte_cnt == '0)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= IDX_W'(FRAME_BYTES)); // R10
    AST_FULL_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == IDX_W'(FRAME_BYTES) && !cs_s && !cs_fall) |=> !commit && byte_cnt == IDX_W'(FRAME_BYTES)); // R10
    AST_DESEL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !commit); // R3

endmodule

// File: rtl/seg_rx_regs.sv
// Module: digit, special-segment and mode registers.
// Writes a committed byte to the register picked by its index; the
// last index is the trailer (special bits plus control nibble).
module seg_rx_regs
    import seg_rx_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    localparam int FRAME_BYTES = NUM_DIGITS + 1,
    localparam int IDX_W = $clog2(FRAME_BYTES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [IDX_W-1:0]             commit_idx,
    input  logic [BYTE_W-1:0]            commit_byte,
    output logic [NUM_DIGITS*BYTE_W-1:0] digit_q,
    output logic [NIB_W-1:0]             sp_q,
    output rx_mode_t                     mode_q
);

    logic              is_ctrl;
    logic [NIB_W-1:0]  ctrl_nib;

    assign is_ctrl  = commit && (commit_idx == IDX_W'(NUM_DIGITS));
    assign ctrl_nib = commit_byte[BYTE_W-1:NIB_W];

    genvar g;
    generate
        for (g = 0; g < NUM_DIGITS; g++) begin : g_digit
            // Load digit g when its byte index is committed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    digit_q[g*BYTE_W +: BYTE_W] <= '0;
                else if (commit && commit_idx == IDX_W'(g))
                    digit_q[g*BYTE_W +: BYTE_W] <= commit_byte;
            end
        end
    endgenerate

    // Trailer byte: special bits always, mode only for a known code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            mode_q <= MODE_ALONE;
        end else if (is_ctrl) begin
            sp_q   <= commit_byte[NIB_W-1:0];
            mode_q <= ctrl_decode(ctrl_nib, mode_q);
        end
    end

    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(digit_q)); // R4
    AST_UNKNOWN_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && !ctrl_known(ctrl_nib)) |=> $stable(mode_q)); // R9
    AST_TRAILER_SP: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl |=> sp_q == $past(commit_byte[NIB_W-1:0])); // R5

endmodule

// File: rtl/seg_serial_rx.sv
// Module: top of the serial segment data receiver.
// Synchronizes the three-wire link, assembles bytes and holds the
// digit, special-segment and mode registers. Assumes each sclk phase
// lasts longer than SYNC_STAGES+1 clk cycles.
module seg_serial_rx
    import seg_rx_pkg::*;
#(
    parameter int NUM_DIGITS  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_BYTES = NUM_DIGITS + 1,
    localparam int IDX_W = $clog2(FRAME_BYTES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sclk,
    input  logic                         sdi,
    output logic [NUM_DIGITS*BYTE_W-1:0] digit_q,
    output logic [NIB_W-1:0]             seg_sp,
    output logic [1:0]                   mode_q,
    output logic                         bpa_osc_in,
    output logic                         bpc_osc_out
);

    logic [2:0]        sync_q;
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [BYTE_W-1:0] commit_byte;
    rx_mode_t          mode;

    seg_rx_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({cs_n, sclk, sdi}),
        .q_sync (sync_q)
    );

    seg_rx_shift #(
        .FRAME_BYTES(FRAME_BYTES)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (sync_q[2]),
        .sclk_s     (sync_q[1]),
        .sdi_s      (sync_q[0]),
        .commit     (commit),
        .commit_idx (commit_idx),
        .commit_byte(commit_byte)
    );

    seg_rx_regs #(
        .NUM_DIGITS(NUM_DIGITS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_idx (commit_idx),
        .commit_byte(commit_byte),
        .digit_q    (digit_q),
        .sp_q       (seg_sp),
        .mode_q     (mode)
    );

    assign mode_q      = mode;
    assign bpa_osc_in  = (mode == MODE_SLAVE);
    assign bpc_osc_out = (mode == MODE_MASTER);

    AST_PIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bpa_osc_in && bpc_osc_out)); // R8
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'd3); // R6

endmodule

// File: tb/test_seg_serial_rx.sv
// Directed bench for seg_serial_rx: one task per scenario.
module test_seg_serial_rx;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [31:0] digit_q;
    logic [3:0]  seg_sp;
    logic [1:0]  mode_q;
    logic        bpa_osc_in, bpc_osc_out;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_serial_rx i_seg_serial_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .digit_q(digit_q), .seg_sp(seg_sp), .mode_q(mode_q),
        .bpa_osc_in(bpa_osc_in), .bpc_osc_out(bpc_osc_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = b[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic select();
        cs_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic frame(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5);
        logic [7:0] bs [6];
        bs = '{b0, b1, b2, b3, b4, b5};
        select();
        for (int k = 0; k < n; k++) send_bits(bs[k], 8);
        deselect();
    endtask

    task automatic check_mode(input string tag, input logic [1:0] m);
        chk({tag, " mode"}, {30'd0, mode_q}, {30'd0, m});
        chk({tag, " bpa"}, {31'd0, bpa_osc_in}, {31'd0, m == 2'd2});
        chk({tag, " bpc"}, {31'd0, bpc_osc_out}, {31'd0, m == 2'd1});
    endtask

    task automatic t_reset();
        chk("R11 digits", digit_q, 32'h0);
        chk("R11 sp", {28'd0, seg_sp}, 32'h0);
        check_mode("R11", 2'd0);
    endtask

    task automatic t_full_frame();
        frame(5, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h35, 8'h00);
        chk("R2 digits order", digit_q, 32'hD4C3B2A1);
        chk("R5 sp", {28'd0, seg_sp}, 32'h5);
        check_mode("R6", 2'd0);
    endtask

    task automatic t_partial();
        frame(2, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R1/R4 partial digits", digit_q, 32'hD4C32211);
        chk("R4 sp kept", {28'd0, seg_sp}, 32'h5);
        select();
        send_bits(8'h33, 8);
        send_bits(8'hFF, 4);
        deselect();
        chk("R4 trailing bits dropped", digit_q, 32'hD4C32233);
    endtask

    task automatic t_modes();
        frame(5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h1A, 8'h00);
        chk("R7 digits", digit_q, 32'h04030201);
        chk("R7 sp", {28'd0, seg_sp}, 32'hA);
        check_mode("R7", 2'd1);
        frame(5, 8'h01, 8'h02, 8'h03, 8'h04, 8'hE3, 8'h00);
        check_mode("R8 1110", 2'd2);
        frame(5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h7C, 8'h00);
        check_mode("R9 unknown", 2'd2);
        chk("R9 sp written", {28'd0, seg_sp}, 32'hC);
        frame(5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h10, 8'h00);
        check_mode("R7 again", 2'd1);
        frame(5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h65, 8'h00);
        check_mode("R8 0110", 2'd2);
        chk("R8 sp", {28'd0, seg_sp}, 32'h5);
    endtask

    task automatic t_overflow();
        frame(6, 8'h21, 8'h32, 8'h43, 8'h54, 8'h39, 8'h99);
        chk("R10 extra byte ignored", digit_q, 32'h54433221);
        chk("R10 sp", {28'd0, seg_sp}, 32'h9);
        check_mode("R10", 2'd0);
    endtask

    task automatic t_deselected_clock();
        send_bits(8'h77, 8);
        wait_clk(8);
        chk("R3 clocks while deselected", digit_q, 32'h54433221);
        frame(3, 8'h66, 8'h67, 8'h68, 8'h00, 8'h00, 8'h00);
        frame(1, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R1 restart at digit 1", digit_q, 32'h54686755);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_full_frame();
        t_partial();
        t_modes();
        t_overflow();
        t_deselected_clock();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule